// File: doc/BRIEF.md
# Dual-Mode Pulse Counter Digitizer

This block turns single-cycle event strobes into binary words using one shared 15-bit counter. In signal mode the counter sums strobes on a pulse input over a counting window of programmable length. The window total is the result, and it scales with the mean pulse rate or with the charge of a burst that falls inside the window. In time mode the counter follows a reference tick input during a run. Each hit strobe in that run records the current count as a timestamp.

Results go into a short shift-register buffer, so several timestamps can wait there for readout. A parallel-to-serial stage empties the buffer onto one data line. A one-cycle frame strobe marks the first bit of each word. The counting source is picked by a mode select, which is only taken while nothing is in progress.

Top module: `pulse_digitizer`

## Requirements
- R1: In signal mode (mode_sel_i = 0 with start_i while idle), the result is the number of cycles with pulse_i high among the N cycles after the start cycle, where N = win_len_i. A win_len_i of 0 acts as 1. done_o is high for exactly one cycle, on the cycle after the last window cycle, and the result enters the buffer on that same edge.
- R2: Only the selected source reaches the counter. In signal mode tick_i, hit_i and stop_i have no effect, and pulse_i is ignored outside the window, including the start cycle. In time mode pulse_i has no effect.
- R3: In time mode (mode_sel_i = 1 with start_i while idle), a hit_i in a run stores the number of tick_i-high cycles strictly after the start cycle and strictly before the hit cycle. stop_i ends the run; a hit on the stop cycle is still taken. Hits while idle are ignored.
- R4: The counter wraps from 0x7FFF to 0. A wrap inside a window or run sets ovf_o, which stays set until the next accepted start clears it.
- R5: The buffer holds DEPTH words in arrival order. buf_level_o gives its occupancy, and the word being shifted out does not count toward it.
- R6: A capture that arrives when the buffer is full and no word is leaving on that edge is discarded. It sets drop_o, which stays set until the next accepted start.
- R7: When the serializer is free and buf_level_o is nonzero, the next cycle starts a word on ser_data_o. The word is sent MSB first, one bit per cycle for 15 cycles, and ser_frame_o is high only with the first bit. Words may follow back to back. ser_data_o is 0 when no word is being sent.
- R8: The mode select is sampled only while idle; a start uses the select presented with it. Changes to mode_sel_i, and any start_i, during a window or run are ignored.
- R9: After reset the block is idle in signal mode with every output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel_i | input | 1 | 0 = signal (window count), 1 = time (timestamps) |
| start_i | input | 1 | Begins a window or run when idle; clears flags |
| stop_i | input | 1 | Ends a time-mode run |
| win_len_i | input | 16 | Window length in cycles, sampled at start |
| pulse_i | input | 1 | Rate-encoded event strobe (signal mode) |
| tick_i | input | 1 | Reference tick strobe (time mode) |
| hit_i | input | 1 | Timestamp request (time mode) |
| done_o | output | 1 | One-cycle window completion pulse |
| ovf_o | output | 1 | Sticky counter wrap flag |
| drop_o | output | 1 | Sticky discarded-capture flag |
| buf_level_o | output | 3 | Words waiting in the buffer |
| ser_data_o | output | 1 | Serial result bit, MSB first |
| ser_frame_o | output | 1 | High with the first bit of each word |

## Verification
Signal mode is swept over window lengths 0, 1, 2, 3, 7, 16 and 40, each with four pulse patterns: none, every cycle, odd cycles and every third cycle. Empty and saturated patterns separate an off-by-one window edge from a miscount. The sparse patterns show which cycles the window actually covers. Time mode is run with three tick patterns and spaced hits, where the expected stamp of each hit is the tick total before it. A run of back-to-back hits fills the buffer and tests the drop rule. A window longer than 32768 cycles tests wrapping and the overflow flag. Start requests and mode changes during a window or run, and hits outside a run, show up as wrong or extra serial words.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic {
    MODE_SIGNAL = 1'b0,
    MODE_TIME   = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/pd_counter.sv
// Shared binary event counter with wrap detection.
module pd_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign cnt_nx_o = inc_i ? cnt_q + 1'b1 : cnt_q;
  assign wrap_o   = inc_i && (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/pd_control.sv
// Mode, window and run sequencing; decides what the counter sees and
// when a result is captured.
module pd_control
  import pd_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LEN_W-1:0] win_len_i,
  input  logic             pulse_i,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nx_i,
  input  logic             wrap_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             push_o,
  output logic [CNT_W-1:0] push_data_o,
  output logic             flag_clr_o,
  output logic             done_o,
  output logic             ovf_o
);
  seq_state_e       st_q;
  mode_e            mode_q;
  mode_e            req_mode;
  logic [LEN_W-1:0] rem_q;
  logic             done_q;
  logic             ovf_q;
  logic             idle;
  logic             start_ok;
  logic             last_win;

  assign req_mode = mode_e'(mode_sel_i);
  assign idle     = (st_q == ST_IDLE);
  assign start_ok = idle && start_i;
  assign last_win = (st_q == ST_WINDOW) && (rem_q <= LEN_W'(1));

  assign cnt_clr_o   = start_ok || (idle && (req_mode != mode_q));
  assign cnt_inc_o   = ((st_q == ST_WINDOW) && pulse_i) ||
                       ((st_q == ST_RUN) && tick_i);
  assign push_o      = last_win || ((st_q == ST_RUN) && hit_i);
  assign push_data_o = last_win ? cnt_nx_i : cnt_i;
  assign flag_clr_o  = start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_SIGNAL;
      rem_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= last_win;
      if (idle) mode_q <= req_mode;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (req_mode == MODE_SIGNAL) begin
              st_q  <= ST_WINDOW;
              rem_q <= win_len_i;
            end else begin
              st_q  <= ST_RUN;
            end
          end
        end
        ST_WINDOW: begin
          if (rem_q <= LEN_W'(1)) st_q  <= ST_IDLE;
          else                    rem_q <= rem_q - 1'b1;
        end
        ST_RUN: begin
          if (stop_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (start_ok)    ovf_q <= 1'b0;
      else if (wrap_i) ovf_q <= 1'b1;
    end
  end

  assign done_o = done_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/pd_buffer.sv
// Shift-register result buffer: slot 0 is the oldest word.
module pd_buffer #(
  parameter int W     = 15,
  parameter int DEPTH = 4,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_i,
  input  logic [W-1:0]   push_data_i,
  input  logic           pop_i,
  input  logic           clr_drop_i,
  output logic [W-1:0]   head_o,
  output logic [LVW-1:0] level_o,
  output logic           drop_o
);
  logic [W-1:0]   mem [DEPTH];
  logic [LVW-1:0] level_q;
  logic [LVW-1:0] wr_idx;
  logic           push_ok;
  logic           drop_q;

  assign push_ok = push_i && ((level_q < LVW'(DEPTH)) || pop_i);
  assign wr_idx  = pop_i ? level_q - 1'b1 : level_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_ok && (int'(wr_idx) == i))
        mem[i] <= push_data_i;
      else if (pop_i && (i < DEPTH - 1))
        mem[i] <= mem[(i < DEPTH - 1) ? i + 1 : i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      level_q <= level_q + LVW'(push_ok) - LVW'(pop_i);
      if (clr_drop_i)            drop_q <= 1'b0;
      else if (push_i && !push_ok) drop_q <= 1'b1;
    end
  end

  assign head_o  = mem[0];
  assign level_o = level_q;
  assign drop_o  = drop_q;
endmodule

// File: rtl/pd_serializer.sv
// Parallel-to-serial drain, MSB first, frame strobe on the first bit.
module pd_serializer #(
  parameter int W    = 15,
  localparam int BCW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         avail_i,
  input  logic [W-1:0] word_i,
  output logic         pop_o,
  output logic         ser_data_o,
  output logic         ser_frame_o
);
  logic [W-1:0]   sh_q;
  logic [BCW-1:0] left_q;
  logic           frame_q;

  assign pop_o = avail_i && (left_q <= BCW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      left_q  <= '0;
      frame_q <= 1'b0;
    end else if (pop_o) begin
      sh_q    <= word_i;
      left_q  <= BCW'(W);
      frame_q <= 1'b1;
    end else begin
      frame_q <= 1'b0;
      if (left_q > BCW'(1)) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end else begin
        sh_q   <= '0;
        left_q <= '0;
      end
    end
  end

  assign ser_data_o  = sh_q[W-1];
  assign ser_frame_o = frame_q;
endmodule

// File: rtl/pulse_digitizer.sv
module pulse_digitizer #(
  parameter int CNT_W = 15,
  parameter int LEN_W = 16,
  parameter int DEPTH = 4,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LEN_W-1:0] win_len_i,
  input  logic             pulse_i,
  input  logic             tick_i,
  input  logic             hit_i,
  output logic             done_o,
  output logic             ovf_o,
  output logic             drop_o,
  output logic [LVW-1:0]   buf_level_o,
  output logic             ser_data_o,
  output logic             ser_frame_o
);
  logic [CNT_W-1:0] cnt, cnt_nx, push_data, head;
  logic             cnt_clr, cnt_inc, wrap, push, pop, flag_clr;

  pd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .cnt_o(cnt), .cnt_nx_o(cnt_nx), .wrap_o(wrap)
  );

  pd_control #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst(rst), .mode_sel_i(mode_sel_i), .start_i(start_i),
    .stop_i(stop_i), .win_len_i(win_len_i), .pulse_i(pulse_i),
    .tick_i(tick_i), .hit_i(hit_i), .cnt_i(cnt), .cnt_nx_i(cnt_nx),
    .wrap_i(wrap), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .push_o(push), .push_data_o(push_data), .flag_clr_o(flag_clr),
    .done_o(done_o), .ovf_o(ovf_o)
  );

  pd_buffer #(.W(CNT_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .clr_drop_i(flag_clr), .head_o(head),
    .level_o(buf_level_o), .drop_o(drop_o)
  );

  pd_serializer #(.W(CNT_W)) u_ser (
    .clk(clk), .rst(rst), .avail_i(buf_level_o != '0), .word_i(head),
    .pop_o(pop), .ser_data_o(ser_data_o), .ser_frame_o(ser_frame_o)
  );
endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int DEPTH = 4,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           start_i,
  input logic           done_o,
  input logic           ovf_o,
  input logic           drop_o,
  input logic [LVW-1:0] buf_level_o,
  input logic           ser_frame_o
);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_ovf_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !start_i) |=> ovf_o);

  p_level_cap_r5: assert property (@(posedge clk) disable iff (rst)
    int'(buf_level_o) <= DEPTH);

  p_level_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(buf_level_o) <= int'($past(buf_level_o)) + 1));

  p_drop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (drop_o && !start_i) |=> drop_o);

  p_frame_single_r7: assert property (@(posedge clk) disable iff (rst)
    ser_frame_o |=> !ser_frame_o);

  p_frame_needs_data_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_frame_o) |-> ($past(buf_level_o) != '0));
endmodule

bind pulse_digitizer pd_checker #(.DEPTH(DEPTH)) u_pd_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .ovf_o(ovf_o), .drop_o(drop_o), .buf_level_o(buf_level_o),
  .ser_frame_o(ser_frame_o)
);

// File: tb/tb_pulse_digitizer.sv
`timescale 1ns/1ps
module tb_pulse_digitizer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 0, start = 0, stop = 0, pulse = 0, tick = 0, hit = 0;
  logic [15:0] win_len = '0;
  logic done, ovf, drop, ser_data, ser_frame;
  logic [2:0] level;

  int nchk = 0, nfail = 0;
  int got [256];
  int nwords = 0;
  int exp_w [64];
  int nexp;
  logic [14:0] cur;
  int nbits = 0;
  bit collecting = 0;

  always #4 clk = ~clk;

  pulse_digitizer dut (
    .clk(clk), .rst(rst), .mode_sel_i(mode_sel), .start_i(start),
    .stop_i(stop), .win_len_i(win_len), .pulse_i(pulse), .tick_i(tick),
    .hit_i(hit), .done_o(done), .ovf_o(ovf), .drop_o(drop),
    .buf_level_o(level), .ser_data_o(ser_data), .ser_frame_o(ser_frame)
  );

  // serial decoder: frame marks the MSB, 15 bits follow one per cycle
  always @(negedge clk) begin
    if (ser_frame) begin
      collecting = 1;
      nbits = 0;
    end
    if (collecting) begin
      cur = {cur[13:0], ser_data};
      nbits++;
      if (nbits == 15) begin
        if (nwords < 256) got[nwords] = int'(cur);
        nwords++;
        collecting = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic int pat(input int i, input int p);
    case (p)
      0: return 0;
      1: return 1;
      2: return i % 2;
      default: return (i % 3 == 0) ? 1 : 0;
    endcase
  endfunction

  task automatic wait_words(input int target, input string tag);
    int t = 0;
    while (nwords < target && t < 300) begin
      step();
      t++;
    end
    step();
    chk(nwords == target, tag, nwords, target);
  endtask

  // R1/R2: one signal-mode window with pattern p
  task automatic run_window(input int len, input int p);
    int n = (len == 0) ? 1 : len;
    int sum = 0;
    int base = nwords;
    step();
    start = 1; win_len = 16'(len); pulse = 1; tick = 1;
    step();
    start = 0;
    for (int i = 1; i <= n; i++) begin
      pulse = pat(i, p) != 0;
      sum += pat(i, p);
      hit = (i == 2);
      stop = (i == 1);
      step();
    end
    hit = 0; stop = 0;
    chk(done == 1'b1, "R1 done pulse", done, 1);
    chk(level == 3'd1, "R5 level after capture", level, 1);
    chk(ovf == (sum >= 32768), "R4 overflow flag", ovf, sum >= 32768);
    pulse = 1;
    step();
    chk(done == 1'b0, "R1 done single cycle", done, 0);
    step(); step();
    pulse = 0; tick = 0;
    wait_words(base + 1, "R2 one word per window");
    chk(got[base] == (sum % 32768), "R1 window count", got[base], sum % 32768);
  endtask

  // R3: time-mode run of len cycles, hits at h0 + k*hs, keep = words retained
  task automatic run_time(input int len, input int p, input int h0,
                          input int hs, input int hn, input int keep);
    int acc = 0;
    int base = nwords;
    nexp = 0;
    step();
    start = 1; tick = 1;
    step();
    start = 0;
    chk(drop == 1'b0, "R6 drop cleared by start", drop, 0);
    chk(ovf == 1'b0, "R4 overflow cleared by start", ovf, 0);
    for (int i = 1; i <= len; i++) begin
      bit is_hit = (i >= h0) && ((i - h0) % hs == 0) && ((i - h0) / hs < hn);
      tick = pat(i, p) != 0;
      pulse = 1;
      hit = is_hit;
      stop = (i == len);
      start = (i == 5);
      if (is_hit && nexp < keep) begin
        exp_w[nexp] = acc;
        nexp++;
      end
      acc += pat(i, p);
      step();
      if (is_hit && hn > keep && (i - h0) / hs == hn - 1)
        chk(level == 3'd4, "R5 buffer full level", level, 4);
    end
    stop = 0; tick = 0; pulse = 0; start = 0;
    hit = 1;
    step(); step(); step();
    hit = 0;
    chk(drop == (hn > keep), "R6 drop flag", drop, hn > keep);
    wait_words(base + keep, "R3 timestamp word count");
    for (int k = 0; k < keep; k++)
      chk(got[base + k] == exp_w[k], "R3 timestamp value", got[base + k], exp_w[k]);
  endtask

  initial begin
    #1_600_000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int base;
    int lens [7] = '{0, 1, 2, 3, 7, 16, 40};
    rst = 1;
    repeat (4) step();
    rst = 0;
    step();
    // R9 reset state
    chk(done == 0, "R9 done reset", done, 0);
    chk(ovf == 0, "R9 ovf reset", ovf, 0);
    chk(drop == 0, "R9 drop reset", drop, 0);
    chk(level == 0, "R9 level reset", level, 0);
    chk(ser_data == 0 && ser_frame == 0, "R9 serial idle", ser_data, 0);

    // R1 R2 R7: signal mode sweep
    for (int li = 0; li < 7; li++)
      for (int p = 0; p < 4; p++)
        run_window(lens[li], p);

    // R4: wrap past 0x7FFF
    run_window(32773, 1);
    run_window(3, 1);

    // R8: mode change and start during a window are ignored
    base = nwords;
    step();
    start = 1; win_len = 16'd10; mode_sel = 0;
    step();
    start = 0; mode_sel = 1;
    for (int i = 1; i <= 10; i++) begin
      pulse = pat(i, 2) != 0;
      tick = 1;
      start = (i == 4);
      step();
    end
    start = 0; pulse = 0; tick = 0;
    chk(done == 1, "R8 window completes", done, 1);
    wait_words(base + 1, "R8 word count");
    chk(got[base] == 5, "R8 mode change ignored mid window", got[base], 5);

    // R3: time mode, mode_sel now 1 and taken while idle
    for (int p = 1; p < 4; p++)
      run_time(60, p, 3, 17, 3, 3);
    // R6: burst of six hits into a four-deep buffer
    run_time(70, 1, 50, 1, 6, 5);
    run_time(30, 2, 7, 20, 1, 1);

    // R3: hits while idle ignored
    base = nwords;
    hit = 1;
    repeat (3) step();
    hit = 0;
    repeat (20) step();
    chk(nwords == base, "R3 idle hits ignored", nwords, base);
    chk(level == 0, "R3 idle hits leave buffer empty", level, 0);

    // R8: back to signal mode
    mode_sel = 0;
    step();
    run_window(5, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule